// File: doc/BRIEF.md
# Scan Chain At-Speed Test Sequencer

This block holds a parameterised chain of mux-D scan cells together with a small sequencer that steps the chain through one of three test timelines: a plain slow scan, a two-capture launch scheme, and a scheme where the final shift is itself the launch. The combinational logic under test lives outside the block. It reads the chain through the parallel `func_q` outputs and returns its response on the parallel `func_d` inputs. Test stimulus arrives one bit per shift cycle on `scan_in`, and responses leave on `scan_out`.

A run starts with a one-cycle `start` pulse while the sequencer is idle. The pulse carries a mode code and a pattern count. On every active cycle the sequencer drives `scan_enable` and raises exactly one of two clock-speed requests, slow or fast. The clock generator outside the block acts on that request. Each pattern's response leaves the chain while the next pattern enters it. A final unload empties the last response. When the run ends the block holds a done flag and reports how many cycles the run took.

Top module: `scan_atspeed_seq`

## Requirements
- R1: While reset is asserted, and after it until a start is accepted, `scan_en`, `slow_req`, `fast_req`, `busy`, `done`, `func_q` and `cycle_count` are all zero.
- R2: On an active cycle with `scan_en` high, cell 0 takes `scan_in`, cell i takes cell i-1, and `scan_out` shows the last cell. On an active cycle with `scan_en` low, every cell loads its bit of `func_d`.
- R3: With mode code 2'b00, or the spare code 2'b11, each pattern is N slow shift cycles followed by one slow capture cycle.
- R4: With mode code 2'b01, each pattern is N slow shift cycles followed by two fast capture cycles on consecutive cycles.
- R5: With mode code 2'b10, each pattern is N-1 slow shift cycles, then one fast shift cycle, then one fast capture cycle directly after it.
- R6: The previous contents of the chain appear on `scan_out` while each pattern shifts in, last cell first. After the final pattern, N slow shift cycles unload the last response.
- R7: When a run ends, `cycle_count` equals P*(N+1)+N for mode codes 2'b00, 2'b10 and 2'b11, and P*(N+2)+N for mode code 2'b01. For example, 3 patterns on a 6-cell chain give 27 cycles.
- R8: `busy` is high on every active cycle. `done` rises on the cycle after the last unload shift and stays high until the next start is accepted.
- R9: A `start` pulse, or a change of `mode` or `num_patterns`, while `busy` is high has no effect on the running timeline or on its cycle count.
- R10: On every active cycle exactly one of `slow_req` and `fast_req` is high. While idle both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; accepted only while idle |
| mode | input | 2 | Timeline code: 00 slow scan, 01 double capture, 10 shift launch, 11 as 00 |
| num_patterns | input | PAT_W | Number of patterns in the run |
| scan_in | input | 1 | Serial stimulus bit |
| func_d | input | N | Response from the logic under test |
| func_q | output | N | Chain contents driven to the logic under test |
| scan_out | output | 1 | Serial response bit (last cell) |
| scan_en | output | 1 | High on shift cycles |
| slow_req | output | 1 | Request a slow clock for this cycle |
| fast_req | output | 1 | Request a full-speed clock for this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next start |
| cycle_count | output | CNT_W | Active cycles used by the current or last run |

## Verification
The bench compares the shift/capture and speed sequence of every cycle against a scoreboard. A sequencer that mixed up the launch-and-capture spacing shows up there. If it put the fast edge one cycle early in the shift-launch mode, or left a slow gap between the two captures, the sequence breaks. It also checks the serial stream that overlaps unload and load. An off-by-one in the shift counter, or a chain wired in reverse, sends out response bits in the wrong order. The run length is compared to the closed-form count for each mode, and with a pattern count of one this catches a sequencer that skips or repeats the final unload. A start pulse with a different mode in the middle of a run must leave the timeline unchanged. A design that latched mode at any time would switch to double capture part way through the run.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    MODE_DC  = 2'd0,
    MODE_LOC = 2'd1,
    MODE_LOS = 2'd2
  } test_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SHIFT  = 3'd1,
    ST_CAP1   = 3'd2,
    ST_CAP2   = 3'd3,
    ST_UNLOAD = 3'd4
  } seq_state_e;
endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic se,
  input  logic si,
  input  logic d,
  output logic q
);
  logic q_d;

  always_comb begin
    q_d = q;
    if (step) q_d = se ? si : d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  // R2: a shift step takes the serial input
  a_r2_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && se) |=> (q == $past(si)));
  // R2: a capture step takes the functional input
  a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !se) |=> (q == $past(d)));
endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int N     = 6,
  parameter int PAT_W = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [PAT_W-1:0] npat_i,
  output logic             step_o,
  output logic             scan_en_o,
  output logic             slow_o,
  output logic             fast_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_o
);
  localparam int BIT_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(N - 1);
  localparam logic [PAT_W-1:0] ONE_PAT  = PAT_W'(1);

  seq_state_e       state_q, state_d;
  test_mode_e       mode_q,  mode_d;
  logic [PAT_W-1:0] pat_q,   pat_d;
  logic [BIT_W-1:0] bit_q,   bit_d;
  logic [CNT_W-1:0] cyc_q,   cyc_d;
  logic             done_q,  done_d;
  logic             last_bit, last_pat;

  assign last_bit = (bit_q == LAST_BIT);
  assign last_pat = (pat_q == ONE_PAT);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    pat_d   = pat_q;
    bit_d   = bit_q;
    cyc_d   = cyc_q;
    done_d  = done_q;
    if (state_q != ST_IDLE) cyc_d = cyc_q + 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d  = (mode_i == 2'd3) ? MODE_DC : test_mode_e'(mode_i);
          pat_d   = npat_i;
          bit_d   = '0;
          cyc_d   = '0;
          done_d  = 1'b0;
          state_d = (npat_i == '0) ? ST_UNLOAD : ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (last_bit) begin
          bit_d   = '0;
          state_d = ST_CAP1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      ST_CAP1: begin
        if (mode_q == MODE_LOC) begin
          state_d = ST_CAP2;
        end else begin
          pat_d   = pat_q - 1'b1;
          state_d = last_pat ? ST_UNLOAD : ST_SHIFT;
        end
      end
      ST_CAP2: begin
        pat_d   = pat_q - 1'b1;
        state_d = last_pat ? ST_UNLOAD : ST_SHIFT;
      end
      ST_UNLOAD: begin
        if (last_bit) begin
          bit_d   = '0;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_DC;
      pat_q   <= '0;
      bit_q   <= '0;
      cyc_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pat_q   <= pat_d;
      bit_q   <= bit_d;
      cyc_q   <= cyc_d;
      done_q  <= done_d;
    end
  end

  // Per-cycle controls
  always_comb begin
    busy_o    = (state_q != ST_IDLE);
    step_o    = busy_o;
    scan_en_o = (state_q == ST_SHIFT) || (state_q == ST_UNLOAD);
    fast_o    = ((state_q == ST_SHIFT) && (mode_q == MODE_LOS) && last_bit) ||
                ((state_q == ST_CAP1) && (mode_q != MODE_DC)) ||
                (state_q == ST_CAP2);
    slow_o    = busy_o && !fast_o;
  end

  assign done_o = done_q;
  assign cyc_o  = cyc_q;

  // R4: the response capture follows the launch capture at full speed
  a_r4_loc_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAP1 && mode_q == MODE_LOC) |=> (state_q == ST_CAP2 && fast_o && !scan_en_o));
  // R5: a fast shift is directly followed by a fast capture
  a_r5_los_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en_o && fast_o) |=> (busy_o && !scan_en_o && fast_o));
  // R3: slow scan never requests a fast cycle
  a_r3_dc_slow: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mode_q == MODE_DC) |-> !fast_o);
  // R9: the latched mode holds for the whole run
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(mode_q));
  // R8: done only while idle
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  // R7: every active cycle adds one to the count
  a_r7_cycle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (cyc_q == $past(cyc_q) + 1'b1));
  // R10: exactly one speed request while busy, none when idle
  a_r10_one_speed: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({slow_o, fast_o}) == (busy_o ? 1 : 0));
endmodule

// File: rtl/scan_atspeed_seq.sv
module scan_atspeed_seq #(
  parameter int N     = 6,
  parameter int PAT_W = 4,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [PAT_W-1:0] num_patterns,
  input  logic             scan_in,
  input  logic [N-1:0]     func_d,
  output logic [N-1:0]     func_q,
  output logic             scan_out,
  output logic             scan_en,
  output logic             slow_req,
  output logic             fast_req,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cycle_count
);
  logic         rst_n_i;
  logic         step;
  logic [N:0]   link;

  scan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  scan_seq_ctrl #(.N(N), .PAT_W(PAT_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .start_i   (start),
    .mode_i    (mode),
    .npat_i    (num_patterns),
    .step_o    (step),
    .scan_en_o (scan_en),
    .slow_o    (slow_req),
    .fast_o    (fast_req),
    .busy_o    (busy),
    .done_o    (done),
    .cyc_o     (cycle_count)
  );

  assign link[0] = scan_in;

  for (genvar g = 0; g < N; g++) begin : g_cell
    scan_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n_i),
      .step  (step),
      .se    (scan_en),
      .si    (link[g]),
      .d     (func_d[g]),
      .q     (link[g+1])
    );
  end

  assign func_q   = link[N:1];
  assign scan_out = link[N];

  // R6: shifting moves the serial stream one cell toward the output
  a_r6_chain_moves: assert property (@(posedge clk) disable iff (!rst_n_i)
    (step && scan_en) |=> (func_q[N-1] == $past(func_q[N-2])));
endmodule

// File: tb/scan_atspeed_seq_bench.sv
module scan_atspeed_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 6;
  localparam int PAT_W = 4;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       mode;
  logic [PAT_W-1:0] num_patterns;
  logic             scan_in;
  logic [N-1:0]     func_d, func_q;
  logic             scan_out, scan_en, slow_req, fast_req, busy, done;
  logic [CNT_W-1:0] cycle_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [2:0] exp_tl[$];
  string      exp_tag[$];
  logic       exp_so[$];
  logic       feed_q[$];
  logic [N-1:0] chain_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Logic under test outside the block: rotate left, invert the wrapped bit
  assign func_d = {func_q[N-2:0], ~func_q[N-1]};

  scan_atspeed_seq #(.N(N), .PAT_W(PAT_W), .CNT_W(CNT_W)) u_scan_atspeed_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .num_patterns(num_patterns), .scan_in(scan_in), .func_d(func_d),
    .func_q(func_q), .scan_out(scan_out), .scan_en(scan_en),
    .slow_req(slow_req), .fast_req(fast_req), .busy(busy), .done(done),
    .cycle_count(cycle_count)
  );

  function automatic logic [N-1:0] resp(input logic [N-1:0] v);
    return {v[N-2:0], ~v[N-1]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push_cycle(input logic [2:0] code, input string tag);
    exp_tl.push_back(code);
    exp_tag.push_back(tag);
  endtask

  // Driver: builds the expected timeline and serial streams, then starts the run
  task automatic run(input logic [1:0] m, input int np, input int seed,
                     input bit disturb, input string tag);
    int extra;
    extra = (m == 2'd1) ? 2 : 1;
    for (int p = 0; p < np; p++) begin
      logic [N-1:0] v;
      v = N'((seed + p) * 23 + 9) ^ N'(seed << 2);
      for (int i = N - 1; i >= 0; i--) begin
        exp_so.push_back(chain_m[i]);   // R6 previous contents leave first
        feed_q.push_back(v[i]);
      end
      for (int i = 0; i < N; i++)
        push_cycle((m == 2'd2 && i == N - 1) ? 3'b110 : 3'b101, tag);
      if (m == 2'd1) begin
        push_cycle(3'b010, tag); push_cycle(3'b010, tag);
        chain_m = resp(resp(v));
      end else if (m == 2'd2) begin
        push_cycle(3'b010, tag);
        chain_m = resp(v);
      end else begin
        push_cycle(3'b001, tag);
        chain_m = resp(v);
      end
    end
    for (int i = N - 1; i >= 0; i--) begin
      exp_so.push_back(chain_m[i]);
      push_cycle(3'b101, "R6");
    end
    chain_m = '0;
    @(negedge clk);
    mode = m; num_patterns = PAT_W'(np); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (3) @(negedge clk);
      mode = 2'd1; num_patterns = PAT_W'(9); start = 1'b1;   // R9 ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    check(cycle_count == CNT_W'(np * (N + extra) + N), "R7", "cycle count",
          cycle_count, np * (N + extra) + N);
    check(done && !busy, "R8", "done held, busy low", {done, busy}, 2'b10);
    check(exp_tl.size() == 0 && exp_so.size() == 0, "R6", "scoreboard drained",
          exp_tl.size() + exp_so.size(), 0);
    check(func_q == '0, "R2", "chain after unload of zeros", func_q, 0);
    @(negedge clk);
    check(done && !busy && !slow_req && !fast_req, "R10", "idle quiet after run",
          {done, busy, slow_req, fast_req}, 4'b1000);
  endtask

  // Monitor: pops expected items as the design steps, and feeds scan_in
  initial begin
    scan_in = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && busy) begin
        if (exp_tl.size() == 0) begin
          check(1'b0, "R8", "unexpected active cycle", 1, 0);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_tl.pop_front();
          t = exp_tag.pop_front();
          check({scan_en, fast_req, slow_req} == e, t, "scan_en/fast/slow",
                {scan_en, fast_req, slow_req}, e);
        end
        if (scan_en) begin
          if (exp_so.size() == 0) check(1'b0, "R6", "extra shift", 1, 0);
          else begin
            logic b;
            b = exp_so.pop_front();
            check(scan_out == b, "R6", "scan_out bit", scan_out, b);
          end
          scan_in = (feed_q.size() != 0) ? feed_q.pop_front() : 1'b0;
        end
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 2'd0; num_patterns = '0;
    chain_m = '0;
    repeat (3) @(negedge clk);
    check({scan_en, slow_req, fast_req, busy, done} == 5'b0, "R1", "controls in reset",
          {scan_en, slow_req, fast_req, busy, done}, 0);
    check(func_q == '0 && cycle_count == '0, "R1", "chain and count in reset",
          {func_q, cycle_count}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, done, slow_req, fast_req} == 4'b0, "R1", "idle after reset",
          {busy, done, slow_req, fast_req}, 0);
    run(2'd0, 3, 1, 1'b0, "R3");   // 27 cycles
    run(2'd1, 2, 4, 1'b0, "R4");   // 22 cycles
    run(2'd2, 3, 7, 1'b0, "R5");   // 27 cycles
    run(2'd0, 1, 2, 1'b1, "R9");   // start with LOC during run must not matter
    run(2'd3, 2, 5, 1'b0, "R3");   // spare code acts as slow scan
    run(2'd2, 1, 11, 1'b0, "R5");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected run end");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule